// File: doc/BRIEF.md
# Region-Tagged Address Translation Buffer

This block turns a 64-bit virtual address into a physical address. The three most significant address bits select one of eight region registers, and the selected register supplies a 24-bit region ID. A 16-entry fully associative buffer then looks for a valid entry whose region ID equals that ID and whose page number equals the request's page number. Each entry carries its own page size, and that size decides where the page offset ends and the page number begins.

On a hit, the entry's physical page number is joined with the untouched offset bits. The result is then qualified by two checks. The first is a privilege and access-rights check. The second is a protection-key check against four key registers. The response is registered one cycle after the request. It reports one of three outcomes: a usable translation, a miss that software must resolve by installing an entry and restarting the access, or a fault code.

Software loads entries through an insert port, and the slot is chosen round-robin. It removes entries through a purge port that clears every entry whose range overlaps a given region ID, page and size. It programs the region and key registers through two small write ports. Inserts and purges never produce a lookup response.

Top module: `tlb_xlate`

## Requirements
- R1: The region register indexed by `reqVa[63:61]` supplies the region ID that is compared. An entry with a different region ID never hits, and a rewrite of that register changes which entries a region reaches from the next lookup on.
- R2: Page-size codes are 0=4K, 1=8K, 2=16K, 3=64K, 4=256K, 5=1M, 6=4M, 7=16M, 8=64M and 9=256M. Any other code is treated as 4K. An entry matches when `reqVa[60:12]` equals its stored page number in every bit at or above the entry's size shift.
- R3: On a usable hit, `rspPa` is the entry's physical page number (in 4 KB units) with every bit below the size shift taken from `reqVa`. In all other responses `rspPa` is zero.
- R4: When no valid entry matches, the response has `rspMiss`=1, `rspHit`=0 and `rspFault`=0.
- R5: If the entry's key equals no valid key register, the response carries fault code 1 (key not present).
- R6: A matching key register blocks the access with fault code 2 when the disable bit for the access type is set. The disable bits are: bit0 for read, bit1 for write, bit2 for execute.
- R7: Fault code 3 is raised when the request privilege level is numerically greater than the entry's level, or when the entry's rights bit for the access type is clear. The rights bits are: bit0 read, bit1 write, bit2 execute. `reqAcc` is 0=read, 1=write, 2=execute, and 3 is treated as read.
- R8: The outcomes rank in a fixed order: a miss, then key not present (1), then key disabled (2), then rights (3). Only the highest-ranked outcome is reported.
- R9: `rspValid` is high exactly in the cycle after a cycle with `reqValid` high.
- R10: Inserts fill slots 0, 1, 2 and onward from reset, wrapping after slot 15. The 17th insert therefore overwrites the entry written by the first.
- R11: A purge invalidates every valid entry with the purge region ID whose range overlaps the purge range, judged at the larger of the two page sizes. Entries with another region ID are untouched.
- R12: After reset all entries and key registers are invalid and the region registers hold zero, so any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rrWe | input | 1 | Region register write strobe |
| rrIdx | input | 3 | Region register index |
| rrRid | input | RID_W | Region ID to write |
| keyWe | input | 1 | Key register write strobe |
| keyIdx | input | log2(NUM_KEY) | Key register index |
| keyValid | input | 1 | Valid bit to write |
| keyVal | input | KEY_W | Key value to write |
| keyDis | input | 3 | Disable bits {exec, write, read} |
| insValid | input | 1 | Insert strobe |
| insVpn | input | 49 | Page number (virtual address bits 60:12) |
| insRid | input | RID_W | Region ID of the new entry |
| insSize | input | 4 | Page-size code |
| insPpn | input | PA_W-12 | Physical page number in 4 KB units |
| insPl | input | 2 | Entry privilege level |
| insAr | input | 3 | Rights {exec, write, read} |
| insKey | input | KEY_W | Protection key |
| purValid | input | 1 | Purge strobe |
| purVpn | input | 49 | Purge page number (address bits 60:12) |
| purRid | input | RID_W | Purge region ID |
| purSize | input | 4 | Purge size code |
| reqValid | input | 1 | Lookup request |
| reqVa | input | 64 | Virtual address |
| reqPl | input | 2 | Requesting privilege level |
| reqAcc | input | 2 | Access type |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Usable translation |
| rspMiss | output | 1 | No matching entry |
| rspFault | output | 2 | Fault code |
| rspPa | output | PA_W | Physical address |

## Verification
The checks assume that software never leaves two valid entries that overlap for the same region ID, so at most one entry matches a lookup. The bench therefore inserts only disjoint pages per region ID and clears a range by purge before it reuses that range. The assertions also assume that the request inputs hold defined values whenever `reqValid` is high. The bench drives every input from reset onward and changes inputs only on the falling clock edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VPN_W = 49;  // virtual address bits 60:12

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_KEYMISS = 2'd1,
    FLT_KEYPERM = 2'd2,
    FLT_RIGHTS  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef struct packed {
    logic insEn;
    logic purEn;
    logic rrWe;
    logic keyWe;
  } strobes_t;

  // bit position of the lowest page-number bit for a size code
  function automatic int unsigned sizeShift(input logic [3:0] code);
    case (code)
      4'd1:    return 13;
      4'd2:    return 14;
      4'd3:    return 16;
      4'd4:    return 18;
      4'd5:    return 20;
      4'd6:    return 22;
      4'd7:    return 24;
      4'd8:    return 26;
      4'd9:    return 28;
      default: return 12;
    endcase
  endfunction

  // compare mask over page-number bits 60:12
  function automatic logic [VPN_W-1:0] vpnMask(input logic [3:0] code);
    int unsigned sh;
    sh = sizeShift(code) - 12;
    return {VPN_W{1'b1}} << sh;
  endfunction

  // selects the permission bit for an access type ({exec, write, read})
  function automatic logic accBit(input logic [2:0] bits, input logic [1:0] acc);
    case (acc)
      ACC_WR:  return bits[1];
      ACC_EX:  return bits[2];
      default: return bits[0];
    endcase
  endfunction

endpackage

// File: rtl/tlb_dpath.sv
module tlb_dpath
  import tlb_pkg::*;
#(
  parameter int RID_W   = 24,
  parameter int PA_W    = 50,
  parameter int KEY_W   = 16,
  parameter int NUM_ENT = 16,
  parameter int NUM_KEY = 4,
  localparam int PPN_W  = PA_W - 12,
  localparam int ENT_IW = $clog2(NUM_ENT),
  localparam int KEY_IW = $clog2(NUM_KEY)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ENT_IW-1:0] insSlot,
  input  logic [2:0]        rrIdx,
  input  logic [RID_W-1:0]  rrRid,
  input  logic [KEY_IW-1:0] keyIdx,
  input  logic              keyValid,
  input  logic [KEY_W-1:0]  keyVal,
  input  logic [2:0]        keyDis,
  input  logic [VPN_W-1:0]  insVpn,
  input  logic [RID_W-1:0]  insRid,
  input  logic [3:0]        insSize,
  input  logic [PPN_W-1:0]  insPpn,
  input  logic [1:0]        insPl,
  input  logic [2:0]        insAr,
  input  logic [KEY_W-1:0]  insKey,
  input  logic [VPN_W-1:0]  purVpn,
  input  logic [RID_W-1:0]  purRid,
  input  logic [3:0]        purSize,
  input  logic              reqValid,
  input  logic [63:0]       reqVa,
  input  logic [1:0]        reqPl,
  input  logic [1:0]        reqAcc,
  output logic              lkHit,
  output logic [PA_W-1:0]   lkPa,
  output logic              lkKeyMiss,
  output logic              lkKeyPerm,
  output logic              lkRightsBad
);

  // entry storage
  logic              entValid [NUM_ENT];
  logic [RID_W-1:0]  entRid   [NUM_ENT];
  logic [VPN_W-1:0]  entVpn   [NUM_ENT];
  logic [3:0]        entSize  [NUM_ENT];
  logic [PPN_W-1:0]  entPpn   [NUM_ENT];
  logic [1:0]        entPl    [NUM_ENT];
  logic [2:0]        entAr    [NUM_ENT];
  logic [KEY_W-1:0]  entKey   [NUM_ENT];

  // region and key registers
  logic [RID_W-1:0]  regionRid [8];
  logic              keyRegV   [NUM_KEY];
  logic [KEY_W-1:0]  keyRegK   [NUM_KEY];
  logic [2:0]        keyRegD   [NUM_KEY];

  logic [RID_W-1:0]  curRid;
  logic [VPN_W-1:0]  reqVpn;
  logic [NUM_ENT-1:0] hitVec;
  logic [NUM_ENT-1:0] purVec;

  assign curRid = regionRid[reqVa[63:61]];
  assign reqVpn = reqVa[60:12];

  // per-entry comparators
  for (genvar g = 0; g < NUM_ENT; g++) begin : gEnt
    logic [3:0] wideCode;
    assign wideCode = (sizeShift(entSize[g]) >= sizeShift(purSize)) ? entSize[g] : purSize;
    assign hitVec[g] = entValid[g] && (entRid[g] == curRid) &&
                       (((entVpn[g] ^ reqVpn) & vpnMask(entSize[g])) == '0);
    assign purVec[g] = entValid[g] && (entRid[g] == purRid) &&
                       (((entVpn[g] ^ purVpn) & vpnMask(wideCode)) == '0);

    // R11: an overlapping purge (without a competing insert) leaves the entry invalid
    a_r11_purge_clears: assert property (@(posedge clk) disable iff (!rstN)
      (strb.purEn && !strb.insEn && purVec[g]) |=> !entValid[g]);
  end

  // entry update: purge first, then insert wins its slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        entValid[i] <= 1'b0;
        entRid[i]   <= '0;
        entVpn[i]   <= '0;
        entSize[i]  <= '0;
        entPpn[i]   <= '0;
        entPl[i]    <= '0;
        entAr[i]    <= '0;
        entKey[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (strb.purEn && purVec[i]) entValid[i] <= 1'b0;
        if (strb.insEn && (insSlot == ENT_IW'(i))) begin
          entValid[i] <= 1'b1;
          entRid[i]   <= insRid;
          entVpn[i]   <= insVpn;
          entSize[i]  <= insSize;
          entPpn[i]   <= insPpn;
          entPl[i]    <= insPl;
          entAr[i]    <= insAr;
          entKey[i]   <= insKey;
        end
      end
    end
  end

  // region and key register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < 8; r++) regionRid[r] <= '0;
      for (int k = 0; k < NUM_KEY; k++) begin
        keyRegV[k] <= 1'b0;
        keyRegK[k] <= '0;
        keyRegD[k] <= '0;
      end
    end else begin
      if (strb.rrWe) regionRid[rrIdx] <= rrRid;
      if (strb.keyWe) begin
        keyRegV[keyIdx] <= keyValid;
        keyRegK[keyIdx] <= keyVal;
        keyRegD[keyIdx] <= keyDis;
      end
    end
  end

  // choose the matching entry (lowest index)
  logic [ENT_IW-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = ENT_IW'(i);
    end
  end

  // physical address composition
  logic [PA_W-1:0] offMask;
  always_comb begin
    offMask = PA_W'((64'd1 << sizeShift(entSize[selIdx])) - 64'd1);
    lkPa    = ({entPpn[selIdx], 12'h000} & ~offMask) | (reqVa[PA_W-1:0] & offMask);
  end

  // protection key lookup
  logic       keyFound;
  logic [2:0] keyBits;
  always_comb begin
    keyFound = 1'b0;
    keyBits  = '0;
    for (int k = NUM_KEY - 1; k >= 0; k--) begin
      if (keyRegV[k] && (keyRegK[k] == entKey[selIdx])) begin
        keyFound = 1'b1;
        keyBits  = keyRegD[k];
      end
    end
  end

  assign lkHit       = |hitVec;
  assign lkKeyMiss   = !keyFound;
  assign lkKeyPerm   = keyFound && accBit(keyBits, reqAcc);
  assign lkRightsBad = (reqPl > entPl[selIdx]) || !accBit(entAr[selIdx], reqAcc);

  // R2: software keeps entries disjoint, so one page matches at most
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot0(hitVec));

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int PA_W    = 50,
  localparam int ENT_IW = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic              purValid,
  input  logic              rrWe,
  input  logic              keyWe,
  input  logic              reqValid,
  input  logic              lkHit,
  input  logic [PA_W-1:0]   lkPa,
  input  logic              lkKeyMiss,
  input  logic              lkKeyPerm,
  input  logic              lkRightsBad,
  output strobes_t          strb,
  output logic [ENT_IW-1:0] insSlot,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [1:0]        rspFault,
  output logic [PA_W-1:0]   rspPa
);

  localparam logic [ENT_IW-1:0] LAST_SLOT = ENT_IW'(NUM_ENT - 1);

  assign strb = '{insEn: insValid, purEn: purValid, rrWe: rrWe, keyWe: keyWe};

  // round-robin victim pointer
  always_ff @(posedge clk) begin
    if (!rstN)         insSlot <= '0;
    else if (insValid) insSlot <= (insSlot == LAST_SLOT) ? '0 : insSlot + 1'b1;
  end

  // fixed-priority outcome
  fault_e fltNext;
  always_comb begin
    if (!lkHit)           fltNext = FLT_NONE;
    else if (lkKeyMiss)   fltNext = FLT_KEYMISS;
    else if (lkKeyPerm)   fltNext = FLT_KEYPERM;
    else if (lkRightsBad) fltNext = FLT_RIGHTS;
    else                  fltNext = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= FLT_NONE;
      rspPa    <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= reqValid && lkHit && (fltNext == FLT_NONE);
      rspMiss  <= reqValid && !lkHit;
      rspFault <= reqValid ? fltNext : FLT_NONE;
      rspPa    <= (reqValid && lkHit && (fltNext == FLT_NONE)) ? lkPa : '0;
    end
  end

  // R9: response exactly one cycle after a request
  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r9_no_idle_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R8: a miss carries no fault and no translation
  a_r8_miss_first: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (rspFault == FLT_NONE) && !rspHit);
  // R3: address is zero unless the translation is usable
  a_r3_pa_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspPa == '0));
  // R10: pointer steps by one on each insert below the last slot
  a_r10_rr_step: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insSlot != LAST_SLOT) |=> insSlot == $past(insSlot) + 1'b1);

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int RID_W   = 24,
  parameter int PA_W    = 50,
  parameter int KEY_W   = 16,
  parameter int NUM_ENT = 16,
  parameter int NUM_KEY = 4,
  localparam int PPN_W  = PA_W - 12,
  localparam int ENT_IW = $clog2(NUM_ENT),
  localparam int KEY_IW = $clog2(NUM_KEY)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rrWe,
  input  logic [2:0]        rrIdx,
  input  logic [RID_W-1:0]  rrRid,
  input  logic              keyWe,
  input  logic [KEY_IW-1:0] keyIdx,
  input  logic              keyValid,
  input  logic [KEY_W-1:0]  keyVal,
  input  logic [2:0]        keyDis,
  input  logic              insValid,
  input  logic [48:0]       insVpn,
  input  logic [RID_W-1:0]  insRid,
  input  logic [3:0]        insSize,
  input  logic [PPN_W-1:0]  insPpn,
  input  logic [1:0]        insPl,
  input  logic [2:0]        insAr,
  input  logic [KEY_W-1:0]  insKey,
  input  logic              purValid,
  input  logic [48:0]       purVpn,
  input  logic [RID_W-1:0]  purRid,
  input  logic [3:0]        purSize,
  input  logic              reqValid,
  input  logic [63:0]       reqVa,
  input  logic [1:0]        reqPl,
  input  logic [1:0]        reqAcc,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [1:0]        rspFault,
  output logic [PA_W-1:0]   rspPa
);

  strobes_t          strb;
  logic [ENT_IW-1:0] insSlot;
  logic              lkHit, lkKeyMiss, lkKeyPerm, lkRightsBad;
  logic [PA_W-1:0]   lkPa;

  tlb_ctrl #(.NUM_ENT(NUM_ENT), .PA_W(PA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .purValid(purValid), .rrWe(rrWe), .keyWe(keyWe),
    .reqValid(reqValid),
    .lkHit(lkHit), .lkPa(lkPa), .lkKeyMiss(lkKeyMiss), .lkKeyPerm(lkKeyPerm),
    .lkRightsBad(lkRightsBad),
    .strb(strb), .insSlot(insSlot),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspFault(rspFault), .rspPa(rspPa)
  );

  tlb_dpath #(
    .RID_W(RID_W), .PA_W(PA_W), .KEY_W(KEY_W),
    .NUM_ENT(NUM_ENT), .NUM_KEY(NUM_KEY)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .insSlot(insSlot),
    .rrIdx(rrIdx), .rrRid(rrRid),
    .keyIdx(keyIdx), .keyValid(keyValid), .keyVal(keyVal), .keyDis(keyDis),
    .insVpn(insVpn), .insRid(insRid), .insSize(insSize), .insPpn(insPpn),
    .insPl(insPl), .insAr(insAr), .insKey(insKey),
    .purVpn(purVpn), .purRid(purRid), .purSize(purSize),
    .reqValid(reqValid), .reqVa(reqVa), .reqPl(reqPl), .reqAcc(reqAcc),
    .lkHit(lkHit), .lkPa(lkPa), .lkKeyMiss(lkKeyMiss), .lkKeyPerm(lkKeyPerm),
    .lkRightsBad(lkRightsBad)
  );

endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;

  localparam int PA_W = 50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rrWe = 0;       logic [2:0] rrIdx = 0;  logic [23:0] rrRid = 0;
  logic        keyWe = 0;      logic [1:0] keyIdx = 0; logic keyValid = 0;
  logic [15:0] keyVal = 0;     logic [2:0] keyDis = 0;
  logic        insValid = 0;   logic [48:0] insVpn = 0; logic [23:0] insRid = 0;
  logic [3:0]  insSize = 0;    logic [37:0] insPpn = 0; logic [1:0] insPl = 0;
  logic [2:0]  insAr = 0;      logic [15:0] insKey = 0;
  logic        purValid = 0;   logic [48:0] purVpn = 0; logic [23:0] purRid = 0;
  logic [3:0]  purSize = 0;
  logic        reqValid = 0;   logic [63:0] reqVa = 0;
  logic [1:0]  reqPl = 0;      logic [1:0] reqAcc = 0;
  logic        rspValid, rspHit, rspMiss;
  logic [1:0]  rspFault;
  logic [PA_W-1:0] rspPa;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;  // 250 MHz

  tlb_xlate dut (
    .clk(clk), .rstN(rstN),
    .rrWe(rrWe), .rrIdx(rrIdx), .rrRid(rrRid),
    .keyWe(keyWe), .keyIdx(keyIdx), .keyValid(keyValid), .keyVal(keyVal), .keyDis(keyDis),
    .insValid(insValid), .insVpn(insVpn), .insRid(insRid), .insSize(insSize),
    .insPpn(insPpn), .insPl(insPl), .insAr(insAr), .insKey(insKey),
    .purValid(purValid), .purVpn(purVpn), .purRid(purRid), .purSize(purSize),
    .reqValid(reqValid), .reqVa(reqVa), .reqPl(reqPl), .reqAcc(reqAcc),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspFault(rspFault), .rspPa(rspPa)
  );

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  pl;
    logic [1:0]  acc;
    logic        hit;
    logic        miss;
    logic [1:0]  flt;
    logic [49:0] pa;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{64'h0000_0000_1234_5678, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_ABCD_E678},  // R2 R3 4K hit
    '{64'h0000_0000_1234_6000, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0},            // R4 next page
    '{64'h6000_0000_4ABC_DEF0, 2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 50'h2_3ABC_DEF0},  // R2 256M
    '{64'h6000_0000_5000_0000, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0},            // R4
    '{64'h2000_0000_001F_FFFF, 2'd2, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_005F_FFFF},  // R3 1M
    '{64'h2000_0000_001F_FFFF, 2'd2, 2'd1, 1'b0, 1'b0, 2'd3, 50'h0},            // R7 rights
    '{64'h2000_0000_001F_FFFF, 2'd3, 2'd0, 1'b0, 1'b0, 2'd3, 50'h0},            // R7 level
    '{64'h2000_0000_1234_5678, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0},            // R1 other rid
    '{64'h0000_0000_0800_0010, 2'd3, 2'd1, 1'b0, 1'b0, 2'd2, 50'h0},            // R6 write off
    '{64'h0000_0000_0800_0010, 2'd3, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_0077_7010},  // R6 read ok
    '{64'h0000_0000_0900_0000, 2'd3, 2'd0, 1'b0, 1'b0, 2'd1, 50'h0},            // R5 key absent
    '{64'h0000_0000_0A00_0000, 2'd3, 2'd2, 1'b0, 1'b0, 2'd2, 50'h0},            // R8 key before rights
    '{64'h0000_0000_0A00_0004, 2'd3, 2'd1, 1'b1, 1'b0, 2'd0, 50'h0_0099_9004},  // R7 write ok
    '{64'h0000_0000_0B00_1234, 2'd3, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_00AA_1234},  // R2 8K
    '{64'h0000_0000_0B00_2000, 2'd3, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0}             // R2 8K edge
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setRegion(input int idx, input logic [23:0] rid);
    @(negedge clk); rrWe = 1; rrIdx = idx[2:0]; rrRid = rid;
    @(negedge clk); rrWe = 0;
  endtask

  task automatic setKey(input int idx, input bit v, input logic [15:0] k, input logic [2:0] d);
    @(negedge clk); keyWe = 1; keyIdx = idx[1:0]; keyValid = v; keyVal = k; keyDis = d;
    @(negedge clk); keyWe = 0;
  endtask

  task automatic insert(input logic [63:0] va, input logic [23:0] rid, input logic [3:0] sz,
                        input logic [37:0] ppn, input logic [1:0] pl, input logic [2:0] ar,
                        input logic [15:0] key);
    @(negedge clk);
    insValid = 1; insVpn = va[60:12]; insRid = rid; insSize = sz;
    insPpn = ppn; insPl = pl; insAr = ar; insKey = key;
    @(negedge clk); insValid = 0;
  endtask

  task automatic purge(input logic [63:0] va, input logic [23:0] rid, input logic [3:0] sz);
    @(negedge clk); purValid = 1; purVpn = va[60:12]; purRid = rid; purSize = sz;
    @(negedge clk); purValid = 0;
  endtask

  // drive one lookup, sample the registered response one cycle later
  task automatic lookup(input logic [63:0] va, input logic [1:0] pl, input logic [1:0] acc,
                        input bit eHit, input bit eMiss, input logic [1:0] eFlt,
                        input logic [49:0] ePa, input string req);
    logic [53:0] act, exp;
    @(negedge clk); reqValid = 1; reqVa = va; reqPl = pl; reqAcc = acc;
    @(negedge clk); reqValid = 0;
    act = {rspHit, rspMiss, rspFault, rspPa};
    exp = {eHit, eMiss, eFlt, ePa};
    check(rspValid === 1'b1, "R9", 64'(rspValid), 64'd1);
    check(act === exp, req, 64'(act), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12: reset state, empty buffer misses
    check(rspValid === 1'b0, "R12", 64'(rspValid), 64'd0);
    lookup(64'h0, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0, "R12");
    @(negedge clk);
    check(rspValid === 1'b0, "R9", 64'(rspValid), 64'd0);

    for (int r = 0; r < 8; r++) setRegion(r, 24'h100 + 24'(r));
    setKey(0, 1, 16'h0011, 3'b000);
    setKey(1, 1, 16'h0022, 3'b010);
    setKey(2, 0, 16'h0033, 3'b000);
    setKey(3, 1, 16'h0044, 3'b100);

    insert(64'h0000_0000_1234_5000, 24'h100, 4'd0, 38'hABCDE,  2'd3, 3'b111, 16'h0011); // slot0
    insert(64'h6000_0000_4000_0000, 24'h103, 4'd9, 38'h230000, 2'd0, 3'b111, 16'h0011); // slot1
    insert(64'h2000_0000_0010_0000, 24'h101, 4'd5, 38'h500,    2'd2, 3'b001, 16'h0011); // slot2
    insert(64'h0000_0000_0800_0000, 24'h100, 4'd0, 38'h777,    2'd3, 3'b111, 16'h0022); // slot3
    insert(64'h0000_0000_0900_0000, 24'h100, 4'd0, 38'h888,    2'd3, 3'b111, 16'h0033); // slot4
    insert(64'h0000_0000_0A00_0000, 24'h100, 4'd0, 38'h999,    2'd3, 3'b011, 16'h0044); // slot5
    insert(64'h0000_0000_0B00_0000, 24'h100, 4'd1, 38'hAA0,    2'd3, 3'b111, 16'h0022); // slot6

    for (int i = 0; i < NV; i++) begin
      lookup(TBL[i].va, TBL[i].pl, TBL[i].acc, TBL[i].hit, TBL[i].miss,
             TBL[i].flt, TBL[i].pa, $sformatf("vector %0d (R1..R8)", i));
    end

    // R1: remapping region 1 to the region-0 ID redirects it
    setRegion(1, 24'h100);
    lookup(64'h2000_0000_1234_5678, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_ABCD_E678, "R1");
    lookup(64'h2000_0000_001F_FFFF, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0, "R1");

    // R11: 256M purge of rid 0x100 block 0, plus a purge with a foreign ID
    purge(64'h0000_0000_0800_0000, 24'h100, 4'd9);
    purge(64'h6000_0000_4000_0000, 24'h999, 4'd9);
    lookup(64'h0000_0000_0800_0010, 2'd3, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0, "R11");
    lookup(64'h0000_0000_0B00_1234, 2'd3, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0, "R11");
    lookup(64'h0000_0000_1234_5678, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_ABCD_E678, "R11");
    lookup(64'h6000_0000_4ABC_DEF0, 2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 50'h2_3ABC_DEF0, "R11");

    // R10: slots 7..15 then wrap to slot 0
    for (int i = 0; i < 10; i++) begin
      insert(64'hA000_0000_0000_0000 | (64'(i) << 12), 24'h105, 4'd0,
             38'h100 + 38'(i), 2'd3, 3'b111, 16'h0011);
    end
    lookup(64'h0000_0000_1234_5678, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0, "R10");
    lookup(64'hA000_0000_0000_9ABC, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_0010_9ABC, "R10");
    lookup(64'hA000_0000_0000_0010, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 50'h0_0010_0010, "R10");
    lookup(64'h6000_0000_4ABC_DEF0, 2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 50'h2_3ABC_DEF0, "R10");

    // R12: reset clears entries again
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    lookup(64'hA000_0000_0000_0010, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 50'h0, "R12");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule